// File: doc/BRIEF.md
# Runtime-Programmable Clock Divider

This block turns a fast base clock into a slower square wave whose frequency is picked while the chip runs. Software or surrounding logic puts the wanted output frequency, in hertz, on a rate input. The base clock frequency is fixed when the block is compiled, through a parameter. An internal counter runs from zero up to a terminal count. The terminal count is the integer quotient of the base frequency over the requested rate, minus one. The output level comes from the counter position, so the low and high phases split each period as evenly as an integer count allows.

The divided output comes straight from a flip-flop clocked by the base clock, so no combinational path reaches it. It is meant for slow, non-critical timing such as tone generation or blink rates. The period is exact only when the base frequency divides evenly by the rate. When the rate changes, the output is not protected from a short or long phase.

A rate of zero parks the block. A rate too high for the base clock is clamped to the fastest legal toggle.

Top module: `rate_divider`

## Requirements
- R1: The base frequency parameter defaults to 50,000,000 Hz, and the rate input is 20 bits wide, which is enough for 1,000,000 Hz. With the defaults and a rate of 1,000,000, the output is low for 25 cycles and high for 25 cycles.
- R2: For a rate r between 1 and half the base frequency, the output period is floor(BASE/r) base clock cycles. This means the terminal count T = floor(BASE/r) - 1.
- R3: After a reset is released, the counter starts at 0 and advances by one on every base clock edge. With T = 9, the output first goes high on the 6th edge after release.
- R4: At the edge where the counter is at or above the current T, the counter becomes 0. If the rate rises so that the counter is already past the new T, the next edge wraps it. With a new T of 3, the output then stays low for 3 edges and rises on the 4th.
- R5: `rst_i` is synchronous and active high. The edge that samples it high drives the output to 0 and the counter to 0. After release, with T = 3, the output reads 0, 0, 1 after the first three edges.
- R6: Counts 0 through floor(T/2) give a low output, and counts above floor(T/2) up to T give a high output. The output shows the level for a count one edge after the counter holds that count. The low phase lasts floor(T/2)+1 cycles and the high phase lasts T-floor(T/2) cycles.
- R7: A rate of 0 never divides by zero. At each edge that sees it, the output goes low and the counter is held at 0. When a non-zero rate with T = 3 returns, the output rises on the 3rd edge.
- R8: If floor(BASE/r) is below 2, which covers any rate above half the base frequency, T is clamped to 1. The output then alternates one cycle low and one cycle high.
- R9: The output changes only at base clock edges. A change on the rate input between edges leaves the output as it was until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock, BASE_HZ hertz |
| rst_i | input | 1 | Synchronous reset, active high |
| rate_hz_i | input | RATE_W (20) | Requested output frequency in hertz, 0 parks the block |
| div_clk_o | output | 1 | Registered divided clock |

## Verification
The bench measures low and high phase lengths at small terminal counts, where an off-by-one in the half-point comparison or in the minus one shows up at once. A divider that compared against the full terminal count, or forgot the subtraction, would stretch each phase by a cycle or give an uneven duty cycle. A rate of zero is driven while the output is high. A design that divided by it or let the counter run would keep toggling. A sudden switch from a very slow rate to a fast one catches a counter that only wraps on exact equality, because that counter would run on for hundreds of cycles. A rate far above the base frequency catches a missing clamp, which would leave the output stuck.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

   // bits needed to hold the value v
   function automatic int bits_for(input longint v);
      int n;
      n = 1;
      while ((longint'(1) << n) <= v) n++;
      return n;
   endfunction

   // where the terminal count is formed
   typedef enum int {
      LIMIT_COMB = 0,
      LIMIT_REG  = 1
   } limit_mode_e;

   localparam longint DEF_BASE_HZ  = 50_000_000;
   localparam longint DEF_MAX_RATE = 1_000_000;

endpackage

// File: rtl/rdiv_limit.sv
module rdiv_limit
   import rdiv_pkg::*;
#(
   parameter longint BASE_HZ = DEF_BASE_HZ,
   parameter int     RATE_W  = 20,
   parameter int     CNT_W   = 26,
   parameter int     MODE    = LIMIT_COMB
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic [CNT_W-1:0]  term_o,
   output logic              idle_o
);

   localparam int DIV_W = (CNT_W > RATE_W) ? CNT_W : RATE_W;
   localparam logic [DIV_W-1:0] BASE_V = DIV_W'(BASE_HZ);

   logic [DIV_W-1:0] quo;
   logic [CNT_W-1:0] term_c;
   logic             idle_c;

   // integer quotient, rate 0 guarded
   always_comb begin
      idle_c = (rate_i == '0);
      if (idle_c) begin
         quo = '0;
      end else begin
         quo = BASE_V / DIV_W'(rate_i);
      end
   end

   // terminal count with floor at 1
   always_comb begin
      if (idle_c) begin
         term_c = CNT_W'(1);
      end else if (quo < DIV_W'(2)) begin
         term_c = CNT_W'(1);
      end else begin
         term_c = CNT_W'(quo - DIV_W'(1));
      end
   end

   generate
      if (MODE == LIMIT_REG) begin : g_reg
         logic [CNT_W-1:0] term_q;
         logic             idle_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               term_q <= CNT_W'(1);
               idle_q <= 1'b1;
            end else begin
               term_q <= term_c;
               idle_q <= idle_c;
            end
         end
         assign term_o = term_q;
         assign idle_o = idle_q;
      end else begin : g_comb
         assign term_o = term_c;
         assign idle_o = idle_c;
      end
   endgenerate

   // R8: terminal count never below one
   p_term_floor_r8 : assert property (@(posedge clk_i) disable iff (rst_i)
      term_o != '0);

endmodule

// File: rtl/rdiv_count.sv
module rdiv_count #(
   parameter int CNT_W = 26
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             idle_i,
   input  logic [CNT_W-1:0] term_i,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             wrap;

   always_comb begin
      wrap = (cnt_q >= term_i);
      if (rst_i || idle_i || wrap) begin
         cnt_d = '0;
      end else begin
         cnt_d = cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk_i) begin
      cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

   // R3: a non-zero count always came from the count before it
   p_cnt_step_r3 : assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));

   // R4: reaching or passing the terminal count wraps on the next edge
   p_cnt_wrap_r4 : assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt_q >= term_i) |=> (cnt_q == '0));

   // R7: parked counter stays at zero
   p_idle_hold_r7 : assert property (@(posedge clk_i) disable iff (rst_i)
      idle_i |=> (cnt_q == '0));

endmodule

// File: rtl/rdiv_level.sv
module rdiv_level #(
   parameter int CNT_W = 26
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             idle_i,
   input  logic [CNT_W-1:0] term_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             lvl_o
);

   logic [CNT_W-1:0] half;
   logic             lvl_d;
   logic             lvl_q;

   always_comb begin
      half  = term_i >> 1;
      lvl_d = 1'b0;
      if (!(rst_i || idle_i)) begin
         lvl_d = (cnt_i > half) && (cnt_i <= term_i);
      end
   end

   always_ff @(posedge clk_i) begin
      lvl_q <= lvl_d;
   end

   assign lvl_o = lvl_q;

   // R6: the output never rises out of count zero
   p_rise_not_zero_r6 : assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(lvl_q) |-> ($past(cnt_i) != '0));

   // R7: parked block drives low on the next edge
   p_idle_low_r7 : assert property (@(posedge clk_i) disable iff (rst_i)
      idle_i |=> !lvl_q);

endmodule

// File: rtl/rate_divider.sv
module rate_divider
   import rdiv_pkg::*;
#(
   parameter longint BASE_HZ    = DEF_BASE_HZ,
   parameter longint MAX_RATE   = DEF_MAX_RATE,
   parameter int     LIMIT_MODE = LIMIT_COMB,
   localparam int    RATE_W     = bits_for(MAX_RATE),
   localparam int    CNT_W      = bits_for(BASE_HZ)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [RATE_W-1:0] rate_hz_i,
   output logic              div_clk_o
);

   generate
      if (BASE_HZ < 2) begin : g_bad_base
         $error("rate_divider: BASE_HZ must be at least 2");
      end
      if (MAX_RATE < 1) begin : g_bad_rate
         $error("rate_divider: MAX_RATE must be at least 1");
      end
      if (LIMIT_MODE != LIMIT_COMB && LIMIT_MODE != LIMIT_REG) begin : g_bad_mode
         $error("rate_divider: LIMIT_MODE out of range");
      end
   endgenerate

   logic [CNT_W-1:0] term;
   logic             idle;
   logic [CNT_W-1:0] cnt;

   rdiv_limit #(
      .BASE_HZ (BASE_HZ),
      .RATE_W  (RATE_W),
      .CNT_W   (CNT_W),
      .MODE    (LIMIT_MODE)
   ) u_limit (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .rate_i (rate_hz_i),
      .term_o (term),
      .idle_o (idle)
   );

   rdiv_count #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .idle_i (idle),
      .term_i (term),
      .cnt_o  (cnt)
   );

   rdiv_level #(
      .CNT_W (CNT_W)
   ) u_level (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .idle_i (idle),
      .term_i (term),
      .cnt_i  (cnt),
      .lvl_o  (div_clk_o)
   );

   // R5: reset drives the output low on the next edge
   p_rst_low_r5 : assert property (@(posedge clk_i)
      rst_i |=> !div_clk_o);

endmodule

// File: tb/sim_rate_divider.sv
module sim_rate_divider;

   localparam int RW = 20;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [RW-1:0] rate = '0;
   logic          dout;
   logic          dout1;
   logic [RW-1:0] rate1 = 20'd1_000_000;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   rate_divider #(.BASE_HZ(1000)) u0 (
      .clk_i     (clk),
      .rst_i     (rst),
      .rate_hz_i (rate),
      .div_clk_o (dout)
   );

   // default parameters for R1
   rate_divider u1 (
      .clk_i     (clk),
      .rst_i     (rst),
      .rate_hz_i (rate1),
      .div_clk_o (dout1)
   );

   typedef struct packed {
      int rate;
      int lo;
      int hi;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{250,     2,   2},   // R2 R6 T=3
      '{100,     5,   5},   // R2 R6 T=9
      '{300,     2,   1},   // R6 T=2, odd period
      '{500,     1,   1},   // R2 R6 T=1
      '{900,     1,   1},   // R8 clamp
      '{600,     1,   1},   // R8 quotient 1
      '{1000000, 1,   1},   // R8 far above base
      '{1,     500, 500},   // R2 T=999
      '{3,     167, 166},   // R2 R6 T=332
      '{7,      71,  71}    // R2 R6 T=141
   };

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // measure phases on output sel (0: u0, 1: u1)
   task automatic measure(input int sel, output int lo, output int hi);
      int guard;
      logic v;
      lo = 0;
      hi = 0;
      guard = 0;
      // find a rising transition
      tick();
      v = sel ? dout1 : dout;
      while (v && guard < 4000) begin tick(); v = sel ? dout1 : dout; guard++; end
      while (!v && guard < 4000) begin tick(); v = sel ? dout1 : dout; guard++; end
      while (v && guard < 4000) begin hi++; tick(); v = sel ? dout1 : dout; guard++; end
      while (!v && guard < 4000) begin lo++; tick(); v = sel ? dout1 : dout; guard++; end
   endtask

   // edges until the first high sample
   task automatic edges_to_rise(output int n);
      n = 0;
      for (int k = 0; k < 2000; k++) begin
         tick();
         n++;
         if (dout) break;
      end
   endtask

   initial begin
      #(8 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int lo;
      int hi;
      int n;
      int cnt_low;

      // reset state, R5
      tick();
      tick();
      check("R5 reset output", int'(dout), 0);
      check("R1 rate width", $bits(rate1), 20);

      // table walk
      rst = 1'b0;
      for (int i = 0; i < 10; i++) begin
         rate = RW'(VECS[i].rate);
         measure(0, lo, hi);
         check($sformatf("R2/R6 rate %0d low", VECS[i].rate), lo, VECS[i].lo);
         check($sformatf("R2/R6 rate %0d high", VECS[i].rate), hi, VECS[i].hi);
      end

      // R1 default base with max rate
      measure(1, lo, hi);
      check("R1 default low", lo, 25);
      check("R1 default high", hi, 25);

      // R5 reset release phase, T=3
      rate = 20'd250;
      rst = 1'b1;
      tick();
      tick();
      check("R5 during reset", int'(dout), 0);
      rst = 1'b0;
      tick(); check("R5 edge1", int'(dout), 0);
      tick(); check("R5 edge2", int'(dout), 0);
      tick(); check("R5 edge3", int'(dout), 1);

      // R3 first rise after reset with T=9
      rate = 20'd100;
      rst = 1'b1;
      tick();
      rst = 1'b0;
      edges_to_rise(n);
      check("R3 first rise T=9", n, 6);

      // R4 wrap when counter passes a new lower terminal
      rate = 20'd1;
      rst = 1'b1;
      tick();
      rst = 1'b0;
      for (int k = 0; k < 50; k++) tick();
      check("R4 slow phase low", int'(dout), 0);
      rate = 20'd250;
      edges_to_rise(n);
      check("R4 rise after wrap", n, 4);

      // R9 and R7: park while high
      rate = 20'd100;
      n = 0;
      while (!dout && n < 100) begin tick(); n++; end
      check("R7 high before park", int'(dout), 1);
      rate = '0;
      #1;
      check("R9 no change between edges", int'(dout), 1);
      tick();
      check("R7 low after park", int'(dout), 0);
      cnt_low = 0;
      for (int k = 0; k < 20; k++) begin
         tick();
         if (!dout) cnt_low++;
      end
      check("R7 held low", cnt_low, 20);
      rate = 20'd250;
      edges_to_rise(n);
      check("R7 restart from zero", n, 3);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule